// File: doc/BRIEF.md
# Priority Memory Chip-Select Decoder

This block turns a 16-bit microcontroller address into one-hot chip selects. There are eight primary flash sector selects, four secondary flash sector selects, one SRAM select and one I/O select. Each select owns a programmable address window held as a base/limit pair. Windows may overlap across tiers. A fixed three-tier priority resolves any overlap: SRAM and I/O win over secondary flash, and secondary flash wins over primary flash.

A small mapping register decides which memory types answer a program-fetch strobe, which answer a data-read strobe, and which answer both. Software can rewrite it at any time to move memories between the two spaces while the system runs. The decode is purely combinational from the address and strobes. Window and mapping registers are written through a simple synchronous port. A flag reports when two windows of the same tier contain the current address.

Top module: `prio_cs_decoder`

## Requirements
- R1: Window w contains address A when base ≤ A ≤ limit, so a one-address window works when base equals limit. A limit below its base leaves the window empty. After reset every window is empty (base FFFFh, limit 0000h), and no select is active.
- R2: Tiers rank SRAM/I/O highest, secondary flash next and primary flash lowest. Only the highest eligible tier that contains the address drives a select.
- R3: With primary 0 at 8000h–BFFFh, secondary 0 at 8000h–9FFFh, SRAM at 8000h–87FFh and all spaces enabled, the decode is as follows on a read: 8000h–87FFh gives SRAM, 8800h–9FFFh gives secondary 0, A000h–BFFFh gives primary 0, and C000h gives nothing.
- R4: No select is active while both strobes are low.
- R5: The mapping register bits are: bit0 SRAM answers fetch, bit1 secondary answers fetch, bit2 primary answers fetch, bit3 secondary answers read, bit4 primary answers read. SRAM always answers read. I/O answers read only and never fetch.
- R6: The mapping register resets to 0Ch. In that state primary flash answers fetch only, while secondary flash, SRAM and I/O answer read.
- R7: Mapping value 14h (bits 2 and 4) lets primary flash answer both fetch and read.
- R8: A tier that does not answer the active strobe is skipped, so a lower tier whose window contains the address is selected instead.
- R9: overlap_err is high whenever two windows of one tier contain the address, independent of the strobes. The decoder then picks the lowest-numbered sector in that tier, and SRAM beats I/O.
- R10: Register address 2w writes the base of window w and 2w+1 writes its limit. Windows 0–7 are primary, 8–11 secondary, 12 SRAM and 13 I/O. Address 28 writes the mapping register from wr_data[4:0]. A write takes effect at the clock edge where wr_en is high and not before.
- R11: At most one select output is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register write port |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | Address to decode |
| fetch_stb | input | 1 | Program-fetch strobe, active high |
| read_stb | input | 1 | Data-read strobe, active high |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| pri_sel | output | 8 | Primary flash sector selects |
| sec_sel | output | 4 | Secondary flash sector selects |
| sram_sel | output | 1 | SRAM select |
| io_sel | output | 1 | I/O select |
| overlap_err | output | 1 | Two windows of one tier contain the address |

## Verification
The hardest case to reach is a fall-through: a higher tier contains the address but is excluded by the mapping register for the active strobe, so a lower tier must answer. The stimulus builds stacked windows at one address range. It then toggles between fetch and read under mapping values 0Ch, 14h and 1Fh, so the same address resolves to SRAM, secondary, primary or nothing. The write timing is probed by checking the decode after the write inputs are driven but before the capturing edge, and again after it.

// File: rtl/csd_pkg.sv
package csd_pkg;
    localparam int MAP_W       = 5;
    localparam int MAP_SRAM_PRG = 0;
    localparam int MAP_SEC_PRG  = 1;
    localparam int MAP_PRI_PRG  = 2;
    localparam int MAP_SEC_DAT  = 3;
    localparam int MAP_PRI_DAT  = 4;

    typedef enum logic [1:0] {
        TIER_NONE = 2'd0,
        TIER_TOP  = 2'd1,
        TIER_MID  = 2'd2,
        TIER_LOW  = 2'd3
    } tier_e;
endpackage

// File: rtl/csd_window_bank.sv
module csd_window_bank
    import csd_pkg::*;
#(
    parameter int AW = 16,
    parameter int NWIN = 14,
    parameter logic [MAP_W-1:0] MAP_RST = 5'h0C,
    parameter int RA_W = $clog2(2*NWIN+1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [RA_W-1:0]           wr_addr,
    input  logic [AW-1:0]             wr_data,
    output logic [NWIN-1:0][AW-1:0]   base_q,
    output logic [NWIN-1:0][AW-1:0]   limit_q,
    output logic [MAP_W-1:0]          map_q
);
    localparam logic [RA_W-1:0] MAP_ADDR = RA_W'(2*NWIN);

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        localparam logic [RA_W-1:0] BASE_ADDR = RA_W'(2*w);
        localparam logic [RA_W-1:0] LIM_ADDR  = RA_W'(2*w+1);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[w]  <= '1;
                limit_q[w] <= '0;
            end else if (wr_en) begin
                if (wr_addr == BASE_ADDR) base_q[w]  <= wr_data;
                if (wr_addr == LIM_ADDR)  limit_q[w] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            map_q <= MAP_RST;
        else if (wr_en && wr_addr == MAP_ADDR) map_q <= wr_data[MAP_W-1:0];
    end

    // R10: mapping write lands on the capturing edge
    a_r10_map_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == MAP_ADDR) |=> map_q == $past(wr_data[MAP_W-1:0]));
endmodule

// File: rtl/csd_range_match.sv
module csd_range_match #(
    parameter int AW = 16,
    parameter int NWIN = 14
) (
    input  logic [AW-1:0]             addr,
    input  logic [NWIN-1:0][AW-1:0]   base,
    input  logic [NWIN-1:0][AW-1:0]   limit,
    output logic [NWIN-1:0]           hit
);
    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
        assign hit[w] = (addr >= base[w]) && (addr <= limit[w]);
    end
endmodule

// File: rtl/csd_tier_pick.sv
module csd_tier_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] hit,
    input  logic [N-1:0] elig,
    output logic [N-1:0] grant,
    output logic         any,
    output logic         multi
);
    logic [N-1:0] req;

    always_comb begin
        req   = hit & elig;
        grant = req & (~req + N'(1));
        any   = |req;
        multi = |(hit & (hit - N'(1)));
    end
endmodule

// File: rtl/prio_cs_decoder.sv
module prio_cs_decoder
    import csd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int N_PRI = 8,
    parameter int N_SEC = 4,
    parameter logic [MAP_W-1:0] MAP_RST = 5'h0C
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [ADDR_W-1:0]                      addr,
    input  logic                                   fetch_stb,
    input  logic                                   read_stb,
    input  logic                                   wr_en,
    input  logic [$clog2(2*(N_PRI+N_SEC+2)+1)-1:0] wr_addr,
    input  logic [ADDR_W-1:0]                      wr_data,
    output logic [N_PRI-1:0]                       pri_sel,
    output logic [N_SEC-1:0]                       sec_sel,
    output logic                                   sram_sel,
    output logic                                   io_sel,
    output logic                                   overlap_err
);
    localparam int NWIN   = N_PRI + N_SEC + 2;
    localparam int SRAM_W = N_PRI + N_SEC;
    localparam int IO_W   = SRAM_W + 1;
    localparam int RA_W   = $clog2(2*NWIN+1);

    logic [NWIN-1:0][ADDR_W-1:0] base_q, limit_q;
    logic [MAP_W-1:0]            map_q;
    logic [NWIN-1:0]             hit;
    logic                        pri_en, sec_en, sram_en, io_en;
    logic [N_PRI-1:0]            pri_g;
    logic [N_SEC-1:0]            sec_g;
    logic [1:0]                  top_g;
    logic                        pri_any, sec_any, top_any;
    logic                        pri_multi, sec_multi, top_multi;
    tier_e                       winner;

    csd_window_bank #(.AW(ADDR_W), .NWIN(NWIN), .MAP_RST(MAP_RST), .RA_W(RA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .base_q(base_q), .limit_q(limit_q), .map_q(map_q)
    );

    csd_range_match #(.AW(ADDR_W), .NWIN(NWIN)) u_match (
        .addr(addr), .base(base_q), .limit(limit_q), .hit(hit)
    );

    always_comb begin
        pri_en  = (fetch_stb && map_q[MAP_PRI_PRG]) || (read_stb && map_q[MAP_PRI_DAT]);
        sec_en  = (fetch_stb && map_q[MAP_SEC_PRG]) || (read_stb && map_q[MAP_SEC_DAT]);
        sram_en = (fetch_stb && map_q[MAP_SRAM_PRG]) || read_stb;
        io_en   = read_stb;
    end

    csd_tier_pick #(.N(N_PRI)) u_pick_pri (
        .hit(hit[N_PRI-1:0]), .elig({N_PRI{pri_en}}),
        .grant(pri_g), .any(pri_any), .multi(pri_multi)
    );

    csd_tier_pick #(.N(N_SEC)) u_pick_sec (
        .hit(hit[SRAM_W-1:N_PRI]), .elig({N_SEC{sec_en}}),
        .grant(sec_g), .any(sec_any), .multi(sec_multi)
    );

    csd_tier_pick #(.N(2)) u_pick_top (
        .hit(hit[IO_W:SRAM_W]), .elig({io_en, sram_en}),
        .grant(top_g), .any(top_any), .multi(top_multi)
    );

    always_comb begin
        if (top_any)      winner = TIER_TOP;
        else if (sec_any) winner = TIER_MID;
        else if (pri_any) winner = TIER_LOW;
        else              winner = TIER_NONE;
    end

    always_comb begin
        pri_sel  = '0;
        sec_sel  = '0;
        sram_sel = 1'b0;
        io_sel   = 1'b0;
        unique case (winner)
            TIER_TOP:  {io_sel, sram_sel} = top_g;
            TIER_MID:  sec_sel = sec_g;
            TIER_LOW:  pri_sel = pri_g;
            TIER_NONE: ;
        endcase
        overlap_err = pri_multi || sec_multi || top_multi;
    end

    // R11: never more than one select
    a_r11_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_sel, sram_sel, sec_sel, pri_sel}));

    // R4: quiet bus gives no select
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_stb && !read_stb) |-> ({io_sel, sram_sel, sec_sel, pri_sel} == '0));

    // R5: I/O only ever answers a read
    a_r5_io_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> read_stb);

    // R5: primary select only in a space the mapping register allows
    a_r5_pri_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (|pri_sel) |-> ((fetch_stb && map_q[MAP_PRI_PRG]) || (read_stb && map_q[MAP_PRI_DAT])));

    // R2: a lower tier is never chosen while an eligible SRAM window contains the address
    a_r2_sram_over_flash: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[SRAM_W] && read_stb) |-> (sec_sel == '0 && pri_sel == '0));
endmodule

// File: tb/prio_cs_decoder_tb.sv
module prio_cs_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        fetch_stb = 1'b0;
    logic        read_stb = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  pri_sel;
    logic [3:0]  sec_sel;
    logic        sram_sel, io_sel, overlap_err;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    prio_cs_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .fetch_stb(fetch_stb), .read_stb(read_stb),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pri_sel(pri_sel), .sec_sel(sec_sel), .sram_sel(sram_sel), .io_sel(io_sel),
        .overlap_err(overlap_err)
    );

    // expected vector layout: {io, sram, sec[3:0], pri[7:0]}
    localparam logic [13:0] NONE = 14'h0000;
    localparam logic [13:0] SRAM = 14'h1000;
    localparam logic [13:0] IO   = 14'h2000;
    function automatic logic [13:0] pri(int i); return 14'(1) << i; endfunction
    function automatic logic [13:0] sec(int i); return 14'(1) << (8 + i); endfunction

    task automatic check(input string req, input logic [13:0] exp, input logic exp_err);
        logic [13:0] got;
        got = {io_sel, sram_sel, sec_sel, pri_sel};
        checks++;
        if (got !== exp || overlap_err !== exp_err) begin
            fails++;
            $display("FAIL %s addr=%h sel=%h err=%b expected sel=%h err=%b",
                     req, addr, got, overlap_err, exp, exp_err);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_win(input int w, input logic [15:0] b, input logic [15:0] l);
        wr(5'(2*w), b);
        wr(5'(2*w+1), l);
    endtask

    task automatic probe(input string req, input logic [15:0] a, input logic f, input logic r,
                         input logic [13:0] exp, input logic exp_err);
        @(negedge clk);
        addr = a; fetch_stb = f; read_stb = r;
        #1;
        check(req, exp, exp_err);
    endtask

    task automatic t_reset;
        probe("R1 reset empty", 16'h0000, 1'b1, 1'b1, NONE, 1'b0);
        probe("R1 reset empty", 16'h8000, 1'b1, 1'b1, NONE, 1'b0);
        probe("R1 reset empty", 16'hFFFF, 1'b1, 1'b1, NONE, 1'b0);
    endtask

    task automatic t_default_map;
        set_win(0, 16'h8000, 16'hBFFF);
        set_win(8, 16'h8000, 16'h9FFF);
        set_win(12, 16'h8000, 16'h87FF);
        probe("R6 read sram", 16'h8400, 1'b0, 1'b1, SRAM, 1'b0);
        probe("R6 read secondary", 16'h9000, 1'b0, 1'b1, sec(0), 1'b0);
        probe("R6 primary not in data", 16'hA000, 1'b0, 1'b1, NONE, 1'b0);
        probe("R6 fetch primary", 16'hA000, 1'b1, 1'b0, pri(0), 1'b0);
        probe("R8 fetch falls to primary", 16'h8400, 1'b1, 1'b0, pri(0), 1'b0);
    endtask

    task automatic t_map_write;
        @(negedge clk);
        addr = 16'hA000; fetch_stb = 1'b0; read_stb = 1'b1;
        wr_addr = 5'd28; wr_data = 16'h0014; wr_en = 1'b1;
        #1;
        check("R10 before edge", NONE, 1'b0);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        check("R10 after edge", pri(0), 1'b0);
        probe("R7 fetch primary", 16'hA000, 1'b1, 1'b0, pri(0), 1'b0);
        probe("R8 secondary skipped", 16'h9000, 1'b0, 1'b1, pri(0), 1'b0);
        probe("R5 sram always read", 16'h8400, 1'b0, 1'b1, SRAM, 1'b0);
    endtask

    task automatic t_example_all;
        wr(5'd28, 16'h001F);
        probe("R3 8000", 16'h8000, 1'b0, 1'b1, SRAM, 1'b0);
        probe("R3 87FF", 16'h87FF, 1'b0, 1'b1, SRAM, 1'b0);
        probe("R3 8800", 16'h8800, 1'b0, 1'b1, sec(0), 1'b0);
        probe("R3 9FFF", 16'h9FFF, 1'b0, 1'b1, sec(0), 1'b0);
        probe("R3 A000", 16'hA000, 1'b0, 1'b1, pri(0), 1'b0);
        probe("R3 BFFF", 16'hBFFF, 1'b0, 1'b1, pri(0), 1'b0);
        probe("R3 C000", 16'hC000, 1'b0, 1'b1, NONE, 1'b0);
        probe("R2 fetch sram tier", 16'h8400, 1'b1, 1'b0, SRAM, 1'b0);
        probe("R2 fetch secondary tier", 16'h9000, 1'b1, 1'b0, sec(0), 1'b0);
    endtask

    task automatic t_idle;
        probe("R4 no strobe", 16'h8400, 1'b0, 1'b0, NONE, 1'b0);
        probe("R4 no strobe", 16'hA000, 1'b0, 1'b0, NONE, 1'b0);
    endtask

    task automatic t_bounds;
        set_win(1, 16'h2000, 16'h1000);
        probe("R1 inverted window", 16'h1800, 1'b1, 1'b0, NONE, 1'b0);
        probe("R1 inverted window", 16'h2000, 1'b1, 1'b0, NONE, 1'b0);
        set_win(1, 16'h3000, 16'h3000);
        probe("R1 single address", 16'h3000, 1'b1, 1'b0, pri(1), 1'b0);
        probe("R1 below single", 16'h2FFF, 1'b1, 1'b0, NONE, 1'b0);
        probe("R1 above single", 16'h3001, 1'b1, 1'b0, NONE, 1'b0);
    endtask

    task automatic t_overlap;
        set_win(2, 16'hC000, 16'hCFFF);
        set_win(3, 16'hC800, 16'hD0FF);
        probe("R9 primary overlap", 16'hC900, 1'b1, 1'b0, pri(2), 1'b1);
        probe("R9 single primary", 16'hD000, 1'b1, 1'b0, pri(3), 1'b0);
        probe("R9 err without strobe", 16'hC900, 1'b0, 1'b0, NONE, 1'b1);
        set_win(9, 16'h4000, 16'h4FFF);
        set_win(10, 16'h4800, 16'h48FF);
        probe("R9 secondary overlap", 16'h4800, 1'b0, 1'b1, sec(1), 1'b1);
        set_win(13, 16'h8400, 16'h84FF);
        probe("R9 sram beats io", 16'h8480, 1'b0, 1'b1, SRAM, 1'b1);
        set_win(13, 16'h6000, 16'h60FF);
        probe("R5 io on read", 16'h6010, 1'b0, 1'b1, IO, 1'b0);
        probe("R5 io ignores fetch", 16'h6010, 1'b1, 1'b0, NONE, 1'b0);
        probe("R11 both strobes one select", 16'h8100, 1'b1, 1'b1, SRAM, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired expected end of test");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_default_map();
        t_map_write();
        t_example_all();
        t_idle();
        t_bounds();
        t_overlap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule